// File: doc/BRIEF.md
# Dual-Level Serial Word Receiver for a 1 Mb/s Command/Response Bus

This block sits behind one differential bus receiver and turns its two complementary data lines into 16-bit words. It oversamples the line with the core clock, hunts for the three-bit-time synchronisation pattern that opens every word, and tells a command/status word from a data word by the polarity of that pattern. It then samples both halves of each of the 17 Manchester-coded bits that follow (16 data bits, then a parity bit). A bit-phase counter is pulled back into line at every mid-bit transition, so the sampling points follow the sender's timing.

When a word is complete, the receiver raises a one-clock strobe. With the strobe come the word, its type and two separate error flags: one for coding violations and one for bad parity. Early in the word, at the centre of the sync pattern, it pulses a command-sync or a data-sync output. A message controller can act on these before the word has finished. An external gap timer can use the strobe and the data-sync pulse to measure the time from one word's parity bit to the next data sync. The core clock may run at 12, 16, 20 or 24 MHz, chosen by a two-bit select.

Top module: `mrx_decoder`

## Requirements
- R1: A word is a 3-bit-time sync, then 16 data bits sent most significant first, then one parity bit. Each bit is Manchester coded: a 1 is sent high-then-low and a 0 low-then-high. A line half is high when pos=1/neg=0 and low when pos=0/neg=1. On the strobe, `word_o` holds the 16 data bits with the first received bit in bit 15.
- R2: `speed_i` values 0, 1, 2 and 3 select 12, 16, 20 and 24 clocks per bit time (half-bit = 6 + 2·speed_i clocks). Words are decoded at each setting.
- R3: A sync whose first 1.5 bit times are high is a command/status sync (`is_cmd_o`=1). A sync whose first 1.5 bit times are low is a data sync (`is_cmd_o`=0). A level run shorter than 2.5 half-bit times is never taken as a sync.
- R4: `cmd_sync_o` pulses for one clock shortly after the centre transition of a command/status sync, well before the strobe. `data_sync_o` pulses the same way for a data sync. Neither pulse fires for the other type.
- R5: Parity is odd over the 16 data bits and the parity bit. If the total count of ones is even, `par_err_o`=1 with the strobe.
- R6: A bit with no transition between its halves, or with pos equal to neg in either half, sets `man_err_o` with that word's strobe. The word still completes on time.
- R7: `valid_o` is high for exactly one clock per word, after the second half of the parity bit has been sampled. The word and flag outputs change only on the strobe cycle and hold their values between strobes.
- R8: The sampling phase is re-centred on mid-bit transitions. Words whose half-bits each deviate by ±1 clock from nominal decode without error.
- R9: After any errored word the receiver hunts for the next sync and decodes it cleanly. Words sent back to back with no gap are all decoded.
- R10: While `rx_en_i` is low, bus activity gives no strobe and no sync pulse. Decoding resumes once it is high again.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low ignores the line |
| rx_pos_i | input | 1 | Positive receiver data line |
| rx_neg_i | input | 1 | Negative receiver data line |
| speed_i | input | 2 | Clock-rate select (12/16/20/24 clocks per bit) |
| word_o | output | 16 | Last received data field |
| is_cmd_o | output | 1 | Last word had a command/status sync |
| valid_o | output | 1 | One-clock word-complete strobe |
| man_err_o | output | 1 | Last word had a coding violation |
| par_err_o | output | 1 | Last word failed odd parity |
| cmd_sync_o | output | 1 | Early pulse on a command/status sync |
| data_sync_o | output | 1 | Early pulse on a data sync |

## Verification
The bench sends words whose half-bits each wander by a clock. A receiver that never re-centres its phase would sample on the wrong side of an edge and report spurious coding errors or shifted data. Back-to-back words merge the parity bit's last half with the next sync's first run. A too-narrow sync window would miss the second word, and one that re-arms too late would drop it. Bits with no mid transition, a half with both lines high, and a flipped parity bit each have to raise only their own flag. A double-length data-like run must not pass for a sync. With the receiver disabled, a loose enable would still emit strobes or early pulses.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    // Line symbol as seen on {pos, neg}
    typedef enum logic [1:0] {
        SYM_IDLE = 2'b00,
        SYM_LO   = 2'b01,
        SYM_HI   = 2'b10,
        SYM_BAD  = 2'b11
    } sym_t;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SYNC2 = 2'd1,
        ST_DATA  = 2'd2
    } rx_st_t;

    function automatic logic sym_ok(input sym_t s);
        return (s == SYM_HI) || (s == SYM_LO);
    endfunction

endpackage

// File: rtl/mrx_line_cond.sv
module mrx_line_cond
    import mrx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pos_i,
    input  logic neg_i,
    output sym_t sym_o,
    output logic edge_o
);

    typedef struct packed {
        logic [1:0] meta;
        logic [1:0] cur;
        logic [1:0] prev;
    } lc_t;

    lc_t lc_d, lc_q;

    always_comb begin
        lc_d.meta = {pos_i, neg_i};
        lc_d.cur  = lc_q.meta;
        lc_d.prev = lc_q.cur;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lc_q <= '0;
        else         lc_q <= lc_d;
    end

    assign sym_o  = sym_t'(lc_q.cur);
    // a clean polarity reversal between two valid symbols
    assign edge_o = ((lc_q.cur == 2'b10) && (lc_q.prev == 2'b01)) ||
                    ((lc_q.cur == 2'b01) && (lc_q.prev == 2'b10));

endmodule

// File: rtl/mrx_sync_det.sv
module mrx_sync_det
    import mrx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hunt_i,
    input  sym_t             sym_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             found_o,
    output logic             cmd_o
);

    typedef struct packed {
        sym_t             lv;
        logic [CNT_W-1:0] rl;
    } sd_t;

    sd_t sd_d, sd_q;
    logic [CNT_W-1:0] win_lo, win_hi;

    assign win_lo = (half_i << 1) + (half_i >> 1);
    assign win_hi = half_i << 2;

    always_comb begin
        sd_d    = sd_q;
        found_o = 1'b0;
        cmd_o   = 1'b0;
        if (!hunt_i || !sym_ok(sym_i)) begin
            sd_d.lv = sym_i;
            sd_d.rl = '0;
        end else if (sym_i == sd_q.lv) begin
            if (sd_q.rl != '1) sd_d.rl = sd_q.rl + 1'b1;
        end else begin
            if (sym_ok(sd_q.lv) && (sd_q.rl >= win_lo) && (sd_q.rl <= win_hi)) begin
                found_o = 1'b1;
                cmd_o   = (sd_q.lv == SYM_HI);
            end
            sd_d.lv = sym_i;
            sd_d.rl = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sd_q.lv <= SYM_IDLE;
            sd_q.rl <= '0;
        end else begin
            sd_q <= sd_d;
        end
    end

endmodule

// File: rtl/mrx_decoder.sv
module mrx_decoder
    import mrx_pkg::*;
#(
    parameter int HALF_BASE = 6,
    parameter int HALF_STEP = 2,
    parameter int DATA_W    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_en_i,
    input  logic              rx_pos_i,
    input  logic              rx_neg_i,
    input  logic [1:0]        speed_i,
    output logic [DATA_W-1:0] word_o,
    output logic              is_cmd_o,
    output logic              valid_o,
    output logic              man_err_o,
    output logic              par_err_o,
    output logic              cmd_sync_o,
    output logic              data_sync_o
);

    localparam int HALF_MAX = HALF_BASE + 3 * HALF_STEP;
    localparam int CNT_W    = $clog2(4 * HALF_MAX + 2);
    localparam int BIT_W    = $clog2(DATA_W + 2);

    typedef struct packed {
        rx_st_t            st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W:0]   shf;
        sym_t              first;
        logic              merr;
        logic              typ;
        logic [DATA_W-1:0] word;
        logic              cmd;
        logic              val;
        logic              merr_o;
        logic              perr_o;
        logic              csync;
        logic              dsync;
    } rx_t;

    rx_t r_d, r_q;

    sym_t sym;
    logic edge_s, found, found_cmd, hunt;
    logic [CNT_W-1:0] half, hh, h3_2, h2m1, h3m1;

    assign half = CNT_W'(HALF_BASE) + CNT_W'(HALF_STEP) * CNT_W'(speed_i);
    assign hh   = half >> 1;
    assign h3_2 = half + hh;
    assign h2m1 = (half << 1) - 1'b1;
    assign h3m1 = half + (half << 1) - 1'b1;
    assign hunt = rx_en_i && (r_q.st == ST_HUNT);

    mrx_line_cond u_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pos_i  (rx_pos_i),
        .neg_i  (rx_neg_i),
        .sym_o  (sym),
        .edge_o (edge_s)
    );

    mrx_sync_det #(.CNT_W(CNT_W)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hunt_i  (hunt),
        .sym_i   (sym),
        .half_i  (half),
        .found_o (found),
        .cmd_o   (found_cmd)
    );

    always_comb begin
        logic bad;
        bad       = 1'b0;
        r_d       = r_q;
        r_d.val   = 1'b0;
        r_d.csync = 1'b0;
        r_d.dsync = 1'b0;
        if (!rx_en_i) begin
            r_d.st = ST_HUNT;
        end else begin
            case (r_q.st)
                ST_HUNT: begin
                    if (found) begin
                        r_d.st    = ST_SYNC2;
                        r_d.cnt   = CNT_W'(1);
                        r_d.typ   = found_cmd;
                        r_d.csync = found_cmd;
                        r_d.dsync = !found_cmd;
                    end
                end
                ST_SYNC2: begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if ((r_q.cnt == h3_2) && (sym != (r_q.typ ? SYM_LO : SYM_HI))) begin
                        r_d.st = ST_HUNT;
                    end else if (r_q.cnt == h3m1) begin
                        r_d.st   = ST_DATA;
                        r_d.cnt  = '0;
                        r_d.bitn = '0;
                        r_d.merr = 1'b0;
                    end
                end
                ST_DATA: begin
                    r_d.cnt = (r_q.cnt == h2m1) ? '0 : r_q.cnt + 1'b1;
                    // phase pull-in: a mid-bit edge marks position half
                    if (edge_s && (r_q.cnt > hh) && (r_q.cnt < h3_2))
                        r_d.cnt = half + 1'b1;
                    if (r_q.cnt == hh) r_d.first = sym;
                    if (r_q.cnt == h3_2) begin
                        bad = !sym_ok(r_q.first) || !sym_ok(sym) || (r_q.first == sym);
                        r_d.shf  = {r_q.shf[DATA_W-1:0], r_q.first == SYM_HI};
                        r_d.merr = r_q.merr | bad;
                        r_d.bitn = r_q.bitn + 1'b1;
                        if (r_q.bitn == BIT_W'(DATA_W)) begin
                            r_d.st     = ST_HUNT;
                            r_d.val    = 1'b1;
                            r_d.word   = r_d.shf[DATA_W:1];
                            r_d.cmd    = r_q.typ;
                            r_d.merr_o = r_d.merr;
                            r_d.perr_o = ~^r_d.shf;
                        end
                    end
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.st    <= ST_HUNT;
            r_q.first <= SYM_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o      = r_q.word;
    assign is_cmd_o    = r_q.cmd;
    assign valid_o     = r_q.val;
    assign man_err_o   = r_q.merr_o;
    assign par_err_o   = r_q.perr_o;
    assign cmd_sync_o  = r_q.csync;
    assign data_sync_o = r_q.dsync;

endmodule

// File: rtl/mrx_decoder_chk.sv
module mrx_decoder_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        rx_en_i,
    input logic        valid_o,
    input logic        cmd_sync_o,
    input logic        data_sync_o,
    input logic [15:0] word_o
);

    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        seen_q <= 1'b0;
        else if (cmd_sync_o || data_sync_o) seen_q <= 1'b1;
        else if (valid_o)                   seen_q <= 1'b0;
    end

    p_valid_one_clock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    p_word_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(word_o) |-> valid_o);

    p_sync_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_sync_o || data_sync_o) |=> !(cmd_sync_o || data_sync_o));

    p_sync_kinds_apart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cmd_sync_o && data_sync_o));

    p_word_after_sync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> seen_q);

    p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_en_i |=> !(valid_o || cmd_sync_o || data_sync_o));

endmodule

bind mrx_decoder mrx_decoder_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_en_i     (rx_en_i),
    .valid_o     (valid_o),
    .cmd_sync_o  (cmd_sync_o),
    .data_sync_o (data_sync_o),
    .word_o      (word_o)
);

// File: tb/mrx_decoder_test.sv
`timescale 1ns/1ps
module mrx_decoder_test;

    logic        clk = 1'b0, rst_n = 1'b0, en = 1'b1, pos = 1'b0, neg = 1'b0;
    logic [1:0]  spd = 2'd0;
    logic [15:0] word;
    logic        is_cmd, valid, merr, perr, csync, dsync;

    mrx_decoder uut (
        .clk_i(clk), .rst_ni(rst_n), .rx_en_i(en), .rx_pos_i(pos), .rx_neg_i(neg),
        .speed_i(spd), .word_o(word), .is_cmd_o(is_cmd), .valid_o(valid),
        .man_err_o(merr), .par_err_o(perr), .cmd_sync_o(csync), .data_sync_o(dsync)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int n_val = 0, n_cs = 0, n_ds = 0, n_wide = 0, cs_at = 0, val_at = 0;
    logic [15:0] w_last = '0, w_prev = '0;
    logic c_last = 0, me_last = 0, pe_last = 0, v_d = 0;

    always @(negedge clk) begin
        cyc++;
        if (valid) begin
            n_val++; val_at = cyc;
            w_prev = w_last; w_last = word;
            c_last = is_cmd; me_last = merr; pe_last = perr;
        end
        if (v_d && valid) n_wide++;
        v_d = valid;
        if (csync) begin n_cs++; cs_at = cyc; end
        if (dsync) n_ds++;
    end

    function automatic logic par_of(input logic [15:0] d);
        return ~^d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic p, input logic n, input int c);
        pos = p; neg = n;
        repeat (c) @(negedge clk);
    endtask

    function automatic int hlen();
        return 6 + 2 * int'(spd);
    endfunction

    task automatic send(input bit cmd, input logic [15:0] d, input bit badpar,
                        input int nomid, input int eqb, input bit jit);
        int h;
        h = hlen();
        if (cmd) begin hold(1, 0, 3*h); hold(0, 1, 3*h); end
        else     begin hold(0, 1, 3*h); hold(1, 0, 3*h); end
        for (int i = 0; i < 17; i++) begin
            logic b;
            int a, c;
            b = (i < 16) ? d[15-i] : (par_of(d) ^ badpar);
            a = h; c = h;
            if (jit) begin
                a = h + int'($urandom_range(2)) - 1;
                c = h + int'($urandom_range(2)) - 1;
            end
            if (i == nomid)    hold(b, ~b, 2*h);
            else if (i == eqb) begin hold(1, 1, h); hold(~b, b, h); end
            else               begin hold(b, ~b, a); hold(~b, b, c); end
        end
    endtask

    task automatic expect_word(input string req, input bit cmd, input logic [15:0] d,
                               input bit me, input bit pe, input int n0);
        chk({req, " strobe count"}, n_val, n0 + 1);
        chk({req, " word"}, w_last, d);
        chk({req, " type"}, c_last, cmd);
        chk({req, " man err"}, me_last, me);
        chk({req, " par err"}, pe_last, pe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0, c0, d0;
        logic [15:0] rd;
        bit rc;
        void'($urandom(32'd1553));
        hold(0, 0, 5);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: outputs at rest after reset
        chk("R11 reset outputs", {word, is_cmd, valid, merr, perr, csync, dsync}, '0);

        // R1 R3 R4 R7: clean command word
        n0 = n_val; c0 = n_cs; d0 = n_ds;
        send(1, 16'hA5C3, 0, -1, -1, 0); hold(0, 0, 4*hlen());
        expect_word("R1 R3 cmd word", 1, 16'hA5C3, 0, 0, n0);
        chk("R4 cmd sync pulse count", n_cs, c0 + 1);
        chk("R4 no data sync on cmd", n_ds, d0);
        chk("R4 sync pulse precedes strobe", cs_at < val_at, 1);

        // R3 R4: data word
        n0 = n_val; c0 = n_cs; d0 = n_ds;
        send(0, 16'h0001, 0, -1, -1, 0); hold(0, 0, 4*hlen());
        expect_word("R3 data word", 0, 16'h0001, 0, 0, n0);
        chk("R4 data sync pulse count", n_ds, d0 + 1);
        chk("R4 no cmd sync on data", n_cs, c0);

        // R5: flipped parity
        n0 = n_val;
        send(1, 16'h7FFE, 1, -1, -1, 0); hold(0, 0, 4*hlen());
        expect_word("R5 bad parity", 1, 16'h7FFE, 0, 1, n0);

        // R6: missing mid-bit transition in bit 5
        n0 = n_val;
        send(0, 16'h3C3C, 0, 5, -1, 0); hold(0, 0, 4*hlen());
        chk("R6 no-mid strobe", n_val, n0 + 1);
        chk("R6 no-mid man err", me_last, 1);

        // R6: both lines high in the parity bit's first half
        n0 = n_val;
        send(1, 16'h1234, 0, -1, 16, 0); hold(0, 0, 4*hlen());
        chk("R6 equal-lines strobe", n_val, n0 + 1);
        chk("R6 equal-lines man err", me_last, 1);

        // R9: clean word right after an errored one
        n0 = n_val;
        send(0, 16'hBEEF, 0, -1, -1, 0); hold(0, 0, 4*hlen());
        expect_word("R9 resync after error", 0, 16'hBEEF, 0, 0, n0);

        // R9: back-to-back words with no gap
        n0 = n_val;
        send(1, 16'h8421, 0, -1, -1, 0);
        send(0, 16'hFFFF, 0, -1, -1, 0); hold(0, 0, 4*hlen());
        chk("R9 contiguous count", n_val, n0 + 2);
        chk("R9 contiguous first", w_prev, 16'h8421);
        chk("R9 contiguous second", w_last, 16'hFFFF);

        // R3: a double-length run is not a sync
        c0 = n_cs; d0 = n_ds;
        hold(1, 0, 2*hlen()); hold(0, 1, 2*hlen()); hold(1, 0, 2*hlen()); hold(0, 0, 6*hlen());
        chk("R3 short run no sync", n_cs + n_ds, c0 + d0);

        // R10: receiver disabled
        n0 = n_val; c0 = n_cs; d0 = n_ds;
        en = 1'b0;
        send(1, 16'h5555, 0, -1, -1, 0); hold(0, 0, 4*hlen());
        chk("R10 no strobe when off", n_val, n0);
        chk("R10 no sync pulse when off", n_cs + n_ds, c0 + d0);
        en = 1'b1; hold(0, 0, 4);
        send(1, 16'h5555, 0, -1, -1, 0); hold(0, 0, 4*hlen());
        expect_word("R10 resumes when on", 1, 16'h5555, 0, 0, n0);

        // R2 R8: every speed, random words with +-1 clock jitter per half
        for (int s = 0; s < 4; s++) begin
            spd = 2'(s);
            hold(0, 0, 8);
            for (int k = 0; k < 6; k++) begin
                rd = 16'($urandom);
                rc = 1'($urandom);
                n0 = n_val;
                send(rc, rd, 0, -1, -1, 1); hold(0, 0, 4*hlen());
                expect_word($sformatf("R2 R8 speed %0d", s), rc, rd, 0, 0, n0);
            end
        end

        // R7: strobe never wider than one clock
        chk("R7 strobe width", n_wide, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule